// File: doc/BRIEF.md
# Multi-Mode Quadrature Down-Mixer

This block sits between an input sample port and a chain of decimating filters. It multiplies each accepted input sample by a cosine/sine word pair from an external oscillator, which shifts the wanted channel down to zero frequency. It produces an in-phase and a quadrature product stream. Three input arrangements are supported: a single real stream, two real streams (A and B) interleaved on one port that share the same oscillator word, and a complex I/Q stream. A bypass arrangement forwards the input unchanged through the same pipeline.

The arrangement is chosen at run time with a two-bit selector. The block copies the selector into its working mode only during reset or on a cycle with the sync input high. This keeps samples that were taken under two different arrangements from mixing in the output. Products are scaled by a fixed power of two and rounded. Every result reaches the outputs a fixed two clock edges after its sample is accepted.

Top module: `quad_mixer`

## Requirements
- R1: While reset is asserted (synchronous, active low), `outValid`, `outChan`, `outI` and `outQ` are all 0 after the next rising edge.
- R2: In mode 0 (single real), an accepted sample gives outI = rnd(I·cos) and outQ = rnd(−I·sin), with `inQ` ignored and `outChan` = 0. Here rnd(x) = floor((x + 2^14) / 2^15).
- R3: In mode 2 (complex), an accepted sample gives outI = rnd(I·cos + Q·sin) and outQ = rnd(Q·cos − I·sin). Full-scale inputs of −32768 on all four operands give outI = 65536 and outQ = 0, with no wrap.
- R4: In mode 3 (bypass), an accepted sample gives outI = I and outQ = Q, sign-extended to 18 bits, and `outChan` = 0.
- R5: In mode 1 (dual real), each accepted sample uses the R2 arithmetic, and `outChan` carries the `chanSel` level it was taken with (0 = A, 1 = B). In every other mode `outChan` is 0.
- R6: In mode 1, the first sample accepted after reset or sync must have `chanSel` = 0. After that, a sample is accepted only if its `chanSel` differs from that of the last accepted sample. Samples that repeat a channel are dropped.
- R7: A sample with `inVld` high that is accepted on a rising edge produces `outValid` high, with its results, after the second rising edge that follows.
- R8: Changes on `modeSel` have no effect on how samples are processed until a reset or a cycle with `syncIn` high.
- R9: A cycle with `syncIn` high accepts no sample, whatever `inVld` is. It loads `modeSel` into the working mode and restarts the A/B order of R6.
- R10: Rounding is half-up: a product of exactly +0.5 LSB rounds to 1, and a product of exactly −0.5 LSB rounds to 0.
- R11: On a cycle where `outValid` is 0, `outI`, `outQ` and `outChan` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeSel | input | 2 | Requested mode: 0 single real, 1 dual real, 2 complex, 3 bypass |
| syncIn | input | 1 | Sync: loads the mode and restarts the A/B order |
| inVld | input | 1 | Input sample present |
| chanSel | input | 1 | A/B select for dual mode (0 = A) |
| inI | input | 16 | Real or in-phase input sample, signed |
| inQ | input | 16 | Quadrature input sample, signed |
| ncoCos | input | 16 | Oscillator cosine word, signed Q15 |
| ncoSin | input | 16 | Oscillator sine word, signed Q15 |
| outValid | output | 1 | Result present |
| outChan | output | 1 | Channel tag of the result |
| outI | output | 18 | In-phase result, signed |
| outQ | output | 18 | Quadrature result, signed |

## Verification
The bench builds the block with its default widths: 16-bit samples and oscillator words, and 18-bit results. With these widths the largest product sum, 2^31, can be driven directly and its 65536 result checked for the absence of wrap. The ±half-LSB rounding ties are also reachable with small operands (±1 times 16384). Random phases switch modes through sync pulses and also change the selector without sync, so both the latched-mode rule and the A/B drop rule are exercised in long mixed runs.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_DUAL = 2'd1,
    MODE_CPLX = 2'd2,
    MODE_PASS = 2'd3
  } mixMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;      // accept this cycle's sample
    logic tag;       // channel tag of the accepted sample
    logic pass;      // bypass the multiply
    logic realOnly;  // force quadrature operand to zero
  } mixStrobe_t;
endpackage

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       syncIn,
  input  logic       inVld,
  input  logic       chanSel,
  output mixStrobe_t stb,
  output mixMode_e   curMode
);
  logic wantB;
  logic chanOk;

  always_comb begin
    chanOk       = (curMode != MODE_DUAL) || (chanSel == wantB);
    stb.take     = inVld && !syncIn && chanOk;
    stb.tag      = (curMode == MODE_DUAL) && chanSel;
    stb.pass     = (curMode == MODE_PASS);
    stb.realOnly = (curMode == MODE_REAL) || (curMode == MODE_DUAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN || syncIn) begin
      curMode <= mixMode_e'(modeSel);
      wantB   <= 1'b0;
    end else if (stb.take && curMode == MODE_DUAL) begin
      wantB <= ~chanSel;
    end
  end
endmodule

// File: rtl/mixer_dp.sv
module mixer_dp
  import mixer_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mixStrobe_t           stb,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  input  logic signed [DW-1:0] ncoCos,
  input  logic signed [DW-1:0] ncoSin,
  output logic                 outValid,
  output logic                 outChan,
  output logic signed [OW-1:0] outI,
  output logic signed [OW-1:0] outQ
);
  localparam int PW = 2 * DW;   // product width
  localparam int SW = PW + 1;   // sum width
  localparam int SH = SW - OW;  // bits dropped by scaling
  localparam logic signed [SW-1:0] HALF = SW'(1) << (SH - 1);

  logic signed [PW-1:0] tA, tB, tC, tD;
  logic signed [PW-1:0] iWide, qWide, cWide, sWide;
  logic signed [PW-1:0] s1A, s1B, s1C, s1D;
  logic                 s1V, s1Tag;
  logic signed [SW-1:0] sumI, sumQ;

  // stage 1 operands: four partial products, or shifted inputs in bypass
  always_comb begin
    iWide = PW'(inI);
    qWide = stb.realOnly ? '0 : PW'(inQ);
    cWide = PW'(ncoCos);
    sWide = PW'(ncoSin);
    if (stb.pass) begin
      tA = iWide <<< SH;
      tB = '0;
      tC = qWide <<< SH;
      tD = '0;
    end else begin
      tA = iWide * cWide;
      tB = qWide * sWide;
      tC = qWide * cWide;
      tD = iWide * sWide;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1V   <= 1'b0;
      s1Tag <= 1'b0;
      s1A   <= '0;
      s1B   <= '0;
      s1C   <= '0;
      s1D   <= '0;
    end else begin
      s1V <= stb.take;
      if (stb.take) begin
        s1Tag <= stb.tag;
        s1A   <= tA;
        s1B   <= tB;
        s1C   <= tC;
        s1D   <= tD;
      end
    end
  end

  // stage 2: combine, round half-up, keep the top OW bits
  always_comb begin
    sumI = $signed({s1A[PW-1], s1A}) + $signed({s1B[PW-1], s1B}) + HALF;
    sumQ = $signed({s1C[PW-1], s1C}) - $signed({s1D[PW-1], s1D}) + HALF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= s1V;
      if (s1V) begin
        outChan <= s1Tag;
        outI    <= sumI[SW-1:SH];
        outQ    <= sumQ[SW-1:SH];
      end
    end
  end
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
  import mixer_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 syncIn,
  input  logic                 inVld,
  input  logic                 chanSel,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  input  logic signed [DW-1:0] ncoCos,
  input  logic signed [DW-1:0] ncoSin,
  output logic                 outValid,
  output logic                 outChan,
  output logic signed [OW-1:0] outI,
  output logic signed [OW-1:0] outQ
);
  mixStrobe_t stb;
  mixMode_e   curMode;

  mixer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncIn(syncIn),
    .inVld(inVld), .chanSel(chanSel), .stb(stb), .curMode(curMode)
  );

  mixer_dp #(.DW(DW), .OW(OW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inI(inI), .inQ(inQ), .ncoCos(ncoCos), .ncoSin(ncoSin),
    .outValid(outValid), .outChan(outChan), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/quad_mixer_chk.sv
module quad_mixer_chk #(
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rstN,
  input logic          syncIn,
  input logic          chanSel,
  input logic          take,
  input logic [1:0]    mode,
  input logic          outValid,
  input logic          outChan,
  input logic [OW-1:0] outI,
  input logic [OW-1:0] outQ
);
  // R7: accepted sample emerges after two edges
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    take |=> ##1 outValid);

  // R9: sync cycle accepts nothing
  p_sync_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> ##1 !outValid);

  // R8: working mode only moves on sync
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !syncIn |=> $stable(mode));

  // R11: outputs hold while no result is presented
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outI) && $stable(outQ) && $stable(outChan)));

  // R5: tag stays zero outside dual mode
  p_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (take && mode != 2'd1) |=> ##1 (outValid && !outChan));

  // R6: two consecutive accepted dual samples never share a channel
  p_alt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (take && mode == 2'd1) |=> !(take && mode == 2'd1 && chanSel == $past(chanSel)));
endmodule

bind quad_mixer quad_mixer_chk #(.OW(OW)) u_chk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .chanSel(chanSel),
  .take(stb.take), .mode(curMode), .outValid(outValid), .outChan(outChan),
  .outI(outI), .outQ(outQ)
);

// File: tb/quad_mixer_tb.sv
module quad_mixer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic syncIn = 1'b0, inVld = 1'b0, chanSel = 1'b0;
  logic signed [15:0] inI = '0, inQ = '0, ncoCos = '0, ncoSin = '0;
  logic outValid, outChan;
  logic signed [17:0] outI, outQ;

  int errors = 0;
  int checks = 0;

  // model state
  int mMode = 0;
  bit mWantB = 1'b0;
  bit e1v, e1c, e2v, e2c;
  logic signed [17:0] e1i, e1q, e2i, e2q;
  string e1t = "R1", e2t = "R1", ovr = "";
  bit lastChs = 1'b1;

  always #10 clk = ~clk;

  quad_mixer u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncIn(syncIn), .inVld(inVld),
    .chanSel(chanSel), .inI(inI), .inQ(inQ), .ncoCos(ncoCos), .ncoSin(ncoSin),
    .outValid(outValid), .outChan(outChan), .outI(outI), .outQ(outQ)
  );

  function automatic logic signed [17:0] rnd(longint x);
    longint y;
    y = (x + 64'sd16384) >>> 15;
    return y[17:0];
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check();
    checks++;
    if (outValid !== e2v || outChan !== e2c || outI !== e2i || outQ !== e2q) begin
      errors++;
      $display("FAIL %s: got v=%0d c=%0d i=%0d q=%0d, expected v=%0d c=%0d i=%0d q=%0d",
               e2t, outValid, outChan, outI, outQ, e2v, e2c, e2i, e2q);
    end
  endtask

  task automatic step(bit rst, bit sync, bit vld, bit chs, logic [1:0] ms,
                      logic signed [15:0] i, logic signed [15:0] q,
                      logic signed [15:0] c, logic signed [15:0] s);
    bit acc;
    longint qo;
    @(negedge clk);
    check();
    e2v = e1v; e2c = e1c; e2i = e1i; e2q = e1q; e2t = e1t;
    if (rst) begin
      e1v = 0; e1c = 0; e1i = '0; e1q = '0; e1t = "R1";
      e2v = 0; e2c = 0; e2i = '0; e2q = '0; e2t = "R1";
      mMode = int'(ms); mWantB = 0;
    end else begin
      acc = vld && !sync && (mMode != 1 || chs == mWantB);
      if (acc) begin
        qo = (mMode >= 2) ? longint'(q) : 0;
        e1v = 1;
        e1c = (mMode == 1) ? chs : 1'b0;
        if (mMode == 3) begin
          e1i = 18'(i); e1q = 18'(q); e1t = "R4";
        end else begin
          e1i = rnd(longint'(i) * longint'(c) + qo * longint'(s));
          e1q = rnd(qo * longint'(c) - longint'(i) * longint'(s));
          e1t = (mMode == 0) ? "R2" : (mMode == 1) ? "R5" : "R3";
        end
      end else begin
        e1v = 0; e1c = e2c; e1i = e2i; e1q = e2q; e1t = "R11";
      end
      if (ovr != "") e1t = ovr;
      if (sync) begin mMode = int'(ms); mWantB = 0; end
      else if (acc && mMode == 1) mWantB = !chs;
    end
    rstN = !rst; syncIn = sync; inVld = vld; chanSel = chs; modeSel = ms;
    inI = i; inQ = q; ncoCos = c; ncoSin = s;
  endtask

  task automatic idle(int n, logic [1:0] ms);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, ms, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0;
    repeat (3) @(negedge clk);
    e1v = 0; e1c = 0; e1i = '0; e1q = '0; e2v = 0; e2c = 0; e2i = '0; e2q = '0;
    mMode = 0;
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outI !== 18'sd0 || outQ !== 18'sd0 || outChan !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0d i=%0d q=%0d, expected v=0 i=0 q=0", outValid, outI, outQ);
    end
    step(1, 0, 0, 0, 2'd0, 0, 0, 0, 0);
    idle(2, 2'd0);

    // R10: half-LSB rounding ties
    ovr = "R10";
    step(0, 0, 1, 0, 2'd0, 16'sd1, 16'sd0, 16'sd16384, 16'sd0);
    step(0, 0, 1, 0, 2'd0, -16'sd1, 16'sd0, 16'sd16384, 16'sd0);
    step(0, 0, 1, 0, 2'd0, -16'sd1, 16'sd7, 16'sd0, 16'sd16384);
    idle(3, 2'd0);

    // R7: single sample through the pipe, latency visible in idle checks
    ovr = "R7";
    step(0, 0, 1, 0, 2'd0, 16'sd1000, 16'sd0, 16'sd32767, 16'sd0);
    idle(3, 2'd0);

    // R3: full-scale complex with no wrap
    ovr = "R3";
    step(0, 1, 0, 0, 2'd2, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2'd2, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768);
    step(0, 0, 1, 0, 2'd2, 16'sd12345, -16'sd321, 16'sd23170, -16'sd23170);
    idle(3, 2'd2);

    // R9: sync cycle with inVld high is dropped
    ovr = "R9";
    step(0, 1, 1, 0, 2'd1, 16'sd500, 0, 16'sd300, 16'sd200);
    idle(3, 2'd1);

    // R6: dual order: B first dropped, A, A dropped, B
    ovr = "R6";
    step(0, 1, 0, 0, 2'd1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 2'd1, 16'sd111, 0, 16'sd20000, 16'sd9000);
    step(0, 0, 1, 0, 2'd1, 16'sd222, 0, 16'sd20000, 16'sd9000);
    step(0, 0, 1, 0, 2'd1, 16'sd333, 0, 16'sd20000, 16'sd9000);
    step(0, 0, 1, 1, 2'd1, 16'sd444, 0, 16'sd20000, 16'sd9000);
    idle(3, 2'd1);

    // R8: selector changes without sync are ignored
    ovr = "R8";
    step(0, 1, 0, 0, 2'd0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2'd3, 16'sd700, 16'sd900, 16'sd16000, 16'sd8000);
    step(0, 0, 1, 1, 2'd2, 16'sd701, 16'sd901, 16'sd16000, 16'sd8000);
    idle(3, 2'd3);

    // R4: bypass
    ovr = "R4";
    step(0, 1, 0, 0, 2'd3, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2'd3, -16'sd32768, 16'sd32767, 16'sd5, 16'sd6);
    idle(3, 2'd3);
    ovr = "";

    // random phases
    for (int p = 0; p < 12; p++) begin
      logic [1:0] pm;
      pm = 2'($urandom % 4);
      if (p == 6) begin
        step(1, 0, 0, 0, pm, 0, 0, 0, 0);
        step(1, 0, 0, 0, pm, 0, 0, 0, 0);
      end else begin
        step(0, 1, 0, 0, pm, 0, 0, 0, 0);
      end
      lastChs = 1'b1;
      for (int k = 0; k < 250; k++) begin
        bit sy, vl, ch;
        logic [1:0] ms;
        sy = ($urandom % 64) == 0;
        vl = ($urandom % 4) != 0;
        ch = (($urandom % 4) == 0) ? lastChs : ~lastChs;
        ms = 2'($urandom % 4);
        step(0, sy, vl, ch, ms, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        if (vl) lastChs = ch;
      end
    end
    idle(3, 2'd0);

    summary();
    $finish;
  end
endmodule